// File: doc/BRIEF.md
# Dual-Bank CMOS RAM Index/Data Port

This block decodes host I/O cycles for two banks of battery-backed CMOS RAM. Each bank is reached through its own index/data register pair. The host first writes a location number into a bank's index register. It then reads or writes that location through the bank's data register. Bank 0 holds the clock's time, calendar, century, alarm and control/status bytes. Bank 1 holds only general-purpose bytes. The block treats every one of these locations as plain storage; it does no timekeeping and raises no alarms or interrupts.

Both banks have a programmable base address, set through a small configuration write port. The top location of each bank does not reach that bank's own storage. Instead, both top locations reach one shared control byte, so a value written through either bank can be read through the other. Reset returns the index registers and the base addresses to their defaults. Reset leaves the storage and the shared byte untouched.

Top module: `cmos_dual_bank_port`

## Requirements
- R1: After reset, both index registers read 0x00. The bank 0 base is 0x070 and the bank 1 base is 0x074.
- R2: The bank 0 index register is at the bank 0 base address, and the bank 0 data register is at that base plus 1.
- R3: The bank 1 index register is at the bank 1 base address, and the bank 1 data register is at that base plus 2. The address bank 1 base plus 1 is not decoded.
- R4: Each index register keeps all 8 written bits and returns them on read-back. Only bits 6:0 choose the location, so an index with bit 7 set reaches the same location as the same index with bit 7 clear.
- R5: Locations 0x00 to 0x7E of bank 0 and of bank 1 are separate bytes. A write through one bank does not change the other bank's byte at the same location.
- R6: Location 0x7F of either bank is one shared byte. A write through either bank's data register can be read back through the other bank's data register.
- R7: A configuration write with cfg_sel = 0 loads the bank 0 low byte, 1 loads the bank 0 high byte, 2 loads the bank 1 low byte and 3 loads the bank 1 high byte. The base address is formed from the high byte's bits 3:0 as address bits 11:8 and the low byte's bits 7:1 as address bits 7:1. Address bit 0 is always 0. The high byte's bits 7:4 and the low byte's bit 0 are ignored.
- R8: A host cycle to an address that matches none of the four ports returns 0x00 on a read. A write to such an address changes nothing.
- R9: When the two banks' port addresses overlap, a bank 0 port at an address takes priority over a bank 1 port at the same address.
- R10: Reset clears the index registers and restores the base addresses. It does not change the stored bytes or the shared byte.
- R11: host_rdata is 0x00 whenever host_rd is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_sel | input | 2 | Selects the configuration byte: 0 = bank 0 low, 1 = bank 0 high, 2 = bank 1 low, 3 = bank 1 high |
| cfg_wdata | input | 8 | Configuration write data |
| host_addr | input | 12 | Host I/O address |
| host_wdata | input | 8 | Host write data |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_rdata | output | 8 | Host read data, combinational, 0x00 when not reading or when no port matches |

## Verification
The hardest case to reach from the ports is two banks whose port addresses overlap. To get there, the bench moves the bank 1 base through the configuration port until bank 1's index port lies on bank 0's index port. It then writes a value that only bank 0 may take, and restores the bank 1 base. A read of bank 1's index afterwards shows whether bank 1 also took the write.

The shared-byte alias needs a similar path. The bench points bank 0's index at 0x7F with bit 7 clear and points bank 1's index at 0x7F with bit 7 set, so the same check also covers the ignored index bit. It then writes through each bank and reads back through the other.

Persistence across reset is checked by writing storage, pulsing reset, and then reloading the index registers to recover the stored bytes.

// File: rtl/cmos_pkg.sv
package cmos_pkg;
    localparam int HADDR_W = 12;
    localparam int DATA_W  = 8;
    localparam int LOC_W   = 7;
    localparam int NBANKS  = 2;

    localparam int LOCS_PER_BANK = 1 << LOC_W;
    localparam int PRIV_PER_BANK = LOCS_PER_BANK - 1;
    localparam int NSLOTS        = NBANKS * PRIV_PER_BANK;
    localparam int SLOT_W        = $clog2(NSLOTS);

    typedef logic [HADDR_W-1:0] haddr_t;
    typedef logic [DATA_W-1:0]  byte_t;
    typedef logic [LOC_W-1:0]   loc_t;

    typedef struct packed {
        logic idx;
        logic dat;
    } bank_hit_t;

    typedef enum logic [1:0] {
        CFG_B0_LO = 2'd0,
        CFG_B0_HI = 2'd1,
        CFG_B1_LO = 2'd2,
        CFG_B1_HI = 2'd3
    } cfg_sel_e;

    // distance of a bank's data port above its index port
    function automatic haddr_t data_offset(input int bank);
        return (bank == 0) ? haddr_t'(1) : haddr_t'(2);
    endfunction

    // the highest location of every bank reaches the shared byte
    function automatic logic is_shared_loc(input loc_t loc);
        return loc == loc_t'(LOCS_PER_BANK - 1);
    endfunction

    function automatic haddr_t make_base(input byte_t hi, input byte_t lo);
        return {hi[HADDR_W-9:0], lo[7:1], 1'b0};
    endfunction
endpackage

// File: rtl/cmos_base_regs.sv
module cmos_base_regs
    import cmos_pkg::*;
#(
    parameter byte_t DEF_B0_HI = 8'h00,
    parameter byte_t DEF_B0_LO = 8'h70,
    parameter byte_t DEF_B1_HI = 8'h00,
    parameter byte_t DEF_B1_LO = 8'h74
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_we,
    input  logic [1:0] cfg_sel,
    input  byte_t      cfg_wdata,
    output haddr_t     base0,
    output haddr_t     base1
);
    byte_t b0_hi_q, b0_lo_q, b1_hi_q, b1_lo_q;
    cfg_sel_e sel;

    assign sel = cfg_sel_e'(cfg_sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            b0_hi_q <= DEF_B0_HI;
            b0_lo_q <= DEF_B0_LO;
            b1_hi_q <= DEF_B1_HI;
            b1_lo_q <= DEF_B1_LO;
        end else if (cfg_we) begin
            unique case (sel)
                CFG_B0_LO: b0_lo_q <= cfg_wdata;
                CFG_B0_HI: b0_hi_q <= cfg_wdata;
                CFG_B1_LO: b1_lo_q <= cfg_wdata;
                CFG_B1_HI: b1_hi_q <= cfg_wdata;
                default:   ;
            endcase
        end
    end

    assign base0 = make_base(b0_hi_q, b0_lo_q);
    assign base1 = make_base(b1_hi_q, b1_lo_q);

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cfg_we |=> ($stable(base0) && $stable(base1))) // R7
        else $error("base moved without config write");

    AST_BASE_EVEN: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> (base0[0] == 1'b0 && base1[0] == 1'b0)) // R7
        else $error("base bit 0 set");
endmodule

// File: rtl/cmos_port_decode.sv
module cmos_port_decode
    import cmos_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  haddr_t    addr,
    input  haddr_t    base0,
    input  haddr_t    base1,
    output bank_hit_t hit [NBANKS]
);
    bank_hit_t raw [NBANKS];
    haddr_t    bases [NBANKS];
    logic      b0_any;

    assign bases[0] = base0;
    assign bases[1] = base1;

    for (genvar b = 0; b < NBANKS; b++) begin : g_bank
        assign raw[b].idx = (addr == bases[b]);
        assign raw[b].dat = (addr == haddr_t'(bases[b] + data_offset(b)));
    end

    // bank 0 wins any overlap; within a bank the index port wins
    assign b0_any = raw[0].idx | raw[0].dat;

    always_comb begin
        hit[0].idx = raw[0].idx;
        hit[0].dat = raw[0].dat & ~raw[0].idx;
        hit[1].idx = raw[1].idx & ~b0_any;
        hit[1].dat = raw[1].dat & ~b0_any & ~raw[1].idx;
    end

    AST_ONE_HIT: assert property (@(posedge clk) disable iff (rst)
        $onehot0({hit[0].idx, hit[0].dat, hit[1].idx, hit[1].dat})) // R9
        else $error("more than one port selected");

    AST_B0_WINS: assert property (@(posedge clk) disable iff (rst)
        (addr == base0) |-> (hit[0].idx && !hit[1].idx && !hit[1].dat)) // R9
        else $error("bank 1 took a bank 0 address");
endmodule

// File: rtl/cmos_store.sv
module cmos_store
    import cmos_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  we,
    input  logic  bank,
    input  loc_t  loc,
    input  byte_t wdata,
    output byte_t rdata,
    output byte_t shared_o
);
    byte_t mem [NSLOTS];
    byte_t shared_q;
    logic [SLOT_W-1:0] slot;
    logic shared_sel;

    assign shared_sel = is_shared_loc(loc);
    assign slot = bank ? SLOT_W'(PRIV_PER_BANK) + SLOT_W'(loc) : SLOT_W'(loc);

    // storage is battery backed: no reset
    always_ff @(posedge clk) begin
        if (we && !shared_sel) mem[slot] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (we && shared_sel) shared_q <= wdata;
    end

    assign rdata    = shared_sel ? shared_q : mem[slot];
    assign shared_o = shared_q;

    AST_SHARED_UNTOUCHED: assert property (@(posedge clk) disable iff (rst)
        (we && !shared_sel) |=> $stable(shared_o)) // R6
        else $error("private write reached shared byte");
endmodule

// File: rtl/cmos_dual_bank_port.sv
module cmos_dual_bank_port
    import cmos_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic [1:0]  cfg_sel,
    input  logic [7:0]  cfg_wdata,
    input  logic [11:0] host_addr,
    input  logic [7:0]  host_wdata,
    input  logic        host_rd,
    input  logic        host_wr,
    output logic [7:0]  host_rdata
);
    haddr_t    base0, base1;
    bank_hit_t hit [NBANKS];
    byte_t     idx_q [NBANKS];
    byte_t     st_rdata, st_shared;
    logic      st_bank, st_we, any_dat, any_hit;
    loc_t      st_loc;

    cmos_base_regs u_base (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .base0(base0), .base1(base1)
    );

    cmos_port_decode u_dec (
        .clk(clk), .rst(rst), .addr(host_addr),
        .base0(base0), .base1(base1), .hit(hit)
    );

    for (genvar b = 0; b < NBANKS; b++) begin : g_idx
        always_ff @(posedge clk) begin
            if (rst)                       idx_q[b] <= '0;
            else if (host_wr && hit[b].idx) idx_q[b] <= host_wdata;
        end

        AST_IDX_HOLD: assert property (@(posedge clk) disable iff (rst)
            !(host_wr && hit[b].idx) |=> $stable(idx_q[b])) // R2
            else $error("index changed without its port");
    end

    assign st_bank = hit[1].dat;
    assign st_loc  = st_bank ? idx_q[1][LOC_W-1:0] : idx_q[0][LOC_W-1:0];
    assign any_dat = hit[0].dat | hit[1].dat;
    assign any_hit = any_dat | hit[0].idx | hit[1].idx;
    assign st_we   = host_wr & any_dat;

    cmos_store u_store (
        .clk(clk), .rst(rst), .we(st_we), .bank(st_bank), .loc(st_loc),
        .wdata(host_wdata), .rdata(st_rdata), .shared_o(st_shared)
    );

    always_comb begin
        host_rdata = '0;
        if (host_rd) begin
            if (hit[0].idx)   host_rdata = idx_q[0];
            else if (hit[1].idx) host_rdata = idx_q[1];
            else if (any_dat) host_rdata = st_rdata;
        end
    end

    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (host_rd && !any_hit) |-> (host_rdata == '0)) // R8
        else $error("unmatched read returned data");

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !host_rd |-> (host_rdata == '0)) // R11
        else $error("read data without read strobe");

    AST_SHARED_ALIAS: assert property (@(posedge clk) disable iff (rst)
        (st_we && is_shared_loc(st_loc)) |=> (st_shared == $past(host_wdata))) // R6
        else $error("shared byte missed a write");
endmodule

// File: tb/tb_cmos_dual_bank_port.sv
module tb_cmos_dual_bank_port;
    logic        clk = 0;
    logic        rst;
    logic        cfg_we;
    logic [1:0]  cfg_sel;
    logic [7:0]  cfg_wdata;
    logic [11:0] host_addr;
    logic [7:0]  host_wdata;
    logic        host_rd, host_wr;
    logic [7:0]  host_rdata;

    int total = 0;
    int bad   = 0;
    logic done = 0;

    always #5 clk = ~clk;

    cmos_dual_bank_port dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rd(host_rd), .host_wr(host_wr), .host_rdata(host_rdata)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic hwr(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1;
        @(negedge clk);
        host_wr = 0;
    endtask

    task automatic hrd(input logic [11:0] a, output logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_rd = 1;
        #1 d = host_rdata;
        host_rd = 0;
    endtask

    task automatic cfg(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        cfg_sel = s; cfg_wdata = d; cfg_we = 1;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1;
        @(negedge clk);
        @(negedge clk);
        rst = 0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        hrd(12'h070, v); check("R1 idx0 after reset", v, 8'h00);
        hrd(12'h074, v); check("R1 idx1 after reset", v, 8'h00);
    endtask

    task automatic t_idle();
        @(negedge clk);
        host_addr = 12'h070; host_rd = 0;
        #1 check("R11 rdata with rd low", host_rdata, 8'h00);
    endtask

    task automatic t_banks();
        logic [7:0] v;
        hwr(12'h070, 8'h05); hwr(12'h071, 8'hA5);
        hwr(12'h074, 8'h05); hwr(12'h076, 8'h5A);
        hrd(12'h070, v); check("R2 idx0 readback", v, 8'h05);
        hrd(12'h071, v); check("R2 data0 at base+1", v, 8'hA5);
        hrd(12'h074, v); check("R3 idx1 readback", v, 8'h05);
        hrd(12'h076, v); check("R5 data1 separate at base+2", v, 8'h5A);
        hwr(12'h071, 8'h11);
        hrd(12'h076, v); check("R5 bank1 untouched by bank0 write", v, 8'h5A);
    endtask

    task automatic t_bit7();
        logic [7:0] v;
        hwr(12'h070, 8'h85);
        hrd(12'h070, v); check("R4 idx bit7 kept", v, 8'h85);
        hrd(12'h071, v); check("R4 bit7 ignored for location", v, 8'h11);
    endtask

    task automatic t_shared();
        logic [7:0] v;
        hwr(12'h070, 8'h7F); hwr(12'h071, 8'h3C);
        hwr(12'h074, 8'hFF);
        hrd(12'h076, v); check("R6 shared via bank1", v, 8'h3C);
        hwr(12'h076, 8'hC3);
        hrd(12'h071, v); check("R6 shared via bank0", v, 8'hC3);
    endtask

    task automatic t_gap();
        logic [7:0] v;
        hrd(12'h075, v); check("R3 base1+1 not decoded", v, 8'h00);
        hwr(12'h075, 8'h99);
        hrd(12'h076, v); check("R3 base1+1 write ignored", v, 8'hC3);
        hwr(12'h300, 8'h42);
        hrd(12'h300, v); check("R8 unmatched read", v, 8'h00);
        hrd(12'h070, v); check("R8 idx0 unchanged", v, 8'h7F);
        hrd(12'h074, v); check("R8 idx1 unchanged", v, 8'hFF);
    endtask

    task automatic t_cfg();
        logic [7:0] v;
        cfg(2'd1, 8'hF3); cfg(2'd0, 8'h41);
        hwr(12'h340, 8'h05);
        hrd(12'h340, v); check("R7 idx0 at new base", v, 8'h05);
        hrd(12'h341, v); check("R7 data0 at new base+1", v, 8'h11);
        hrd(12'h070, v); check("R7 old base released", v, 8'h00);
        cfg(2'd1, 8'h00); cfg(2'd0, 8'h70);
    endtask

    task automatic t_overlap();
        logic [7:0] v;
        hwr(12'h074, 8'h22);
        cfg(2'd2, 8'h70);
        hwr(12'h070, 8'h33);
        hrd(12'h070, v); check("R9 bank0 wins read", v, 8'h33);
        cfg(2'd2, 8'h74);
        hrd(12'h074, v); check("R9 bank1 idx not written", v, 8'h22);
    endtask

    task automatic t_persist();
        logic [7:0] v;
        hwr(12'h070, 8'h05); hwr(12'h071, 8'h6E);
        cfg(2'd0, 8'h20);
        do_reset();
        hrd(12'h070, v); check("R10 idx0 cleared, base restored", v, 8'h00);
        hwr(12'h070, 8'h05);
        hrd(12'h071, v); check("R10 storage kept", v, 8'h6E);
        hwr(12'h070, 8'h7F);
        hrd(12'h071, v); check("R10 shared kept", v, 8'hC3);
    endtask

    initial begin
        rst = 1; cfg_we = 0; cfg_sel = 0; cfg_wdata = 0;
        host_addr = 0; host_wdata = 0; host_rd = 0; host_wr = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_idle();
        t_banks();
        t_bit7();
        t_shared();
        t_gap();
        t_cfg();
        t_overlap();
        t_persist();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule